// File: doc/BRIEF.md
# Base-Limit Address Relocator with Range Guard

This block sits between a processor's address generation and the memory port. Every reference carries a kind, instruction fetch or data operand. The block holds one base/limit pair for each kind. The physical address is the logical address plus the base of the selected pair, so each program sees a logical space that starts at zero. The memory request goes out in the same cycle it is accepted, without waiting for the range check.

The range check runs alongside the add and compares the logical address with the limit of the same pair. The limit is the size of the region. If the check fails, the block raises a fault one cycle later. The fault cancels the response to the request that was already issued. The fault carries a code that names the kind of the failing reference. A vector reference is given as a start address, a stride and an element count. Only its first and last element addresses are checked. A carry out of the last-address calculation is treated as a fault.

The faulting address and its code are held until software clears them. While they are held, no new request is accepted. A privileged write port loads the four registers. There are no permission bits: the range check is the only protection.

Top module: `base_limit_guard`

## Requirements
- R1: `mem_addr_o` equals `req_addr_i` plus the base of the selected pair, modulo 2^AW. It appears in the same cycle as the request, and `mem_valid_o` is high for every accepted request.
- R2: An instruction reference (`req_kind_i`=0) whose logical address is greater than or equal to the instruction limit gives fault code 1.
- R3: A data reference (`req_kind_i`=1) whose logical address is greater than or equal to the data limit gives fault code 2. The data limit is separate from the instruction limit.
- R4: After reset all bases and limits are zero, so every reference faults. The outputs come out of reset with no fault, nothing held, and `req_ready_o` high.
- R5: For a vector reference with a count n>0, the last address is start + stride×(n−1). The reference faults if the start address or the last address is at or above the limit.
- R6: A vector reference whose last-address calculation carries out of AW bits faults, even when the low AW bits are below the limit.
- R7: A vector reference with a count of zero never faults, whatever its start address.
- R8: `fault_o` is high for exactly the one cycle after a faulting request is accepted. `fault_code_o` is 0 when there is no fault, 1 for an instruction range fault and 2 for an operand range fault.
- R9: A fault latches its logical address and code into `err_addr_o`/`err_code_o` and sets `err_valid_o`. These hold until `err_clr_i` is asserted. `req_ready_o` stays low while a fault is held.
- R10: A register write takes effect on the next cycle. A request in the same cycle as the write uses the old value.
- R11: The write select `cfg_sel_i` is encoded as 0 instruction base, 1 instruction limit, 2 data base, 3 data limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Privileged register write strobe |
| cfg_sel_i | input | 2 | Register select (R11) |
| cfg_wdata_i | input | AW | Register write value |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high |
| req_kind_i | input | 1 | 0 instruction fetch, 1 data operand |
| req_vec_i | input | 1 | Vector reference |
| req_addr_i | input | AW | Logical (start) address |
| req_stride_i | input | AW | Vector stride |
| req_len_i | input | LW | Vector element count |
| mem_valid_o | output | 1 | Memory request issued |
| mem_addr_o | output | AW | Physical address |
| fault_o | output | 1 | Cancel the response to last cycle's request |
| fault_code_o | output | 2 | Exception code of that request |
| err_valid_o | output | 1 | A fault is held |
| err_addr_o | output | AW | Held faulting logical address |
| err_code_o | output | 2 | Held exception code |
| err_clr_i | input | 1 | Clear the held fault |

## Verification
The bench probes addresses one below and exactly at each limit. A guard that compared with greater-than instead of greater-or-equal would let the boundary word through. It also checks the limit against the physical address, which would pass or fail the wrong references.

For vectors, the bench uses counts whose last element lands exactly on the limit, a huge stride whose result wraps back below the limit, and a zero count with a start address outside the region. A checker that ignored the carry, tested only the start address, or let a zero count underflow would misreport these cases.

It also writes a base in the same cycle as a fetch, to catch a register file that forwards the new value too early. It checks that a mixed-up pair selection shows up as the wrong exception code.

// File: rtl/relo_pkg.sv
package relo_pkg;
  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_PROG = 2'd1,
    EXC_OPER = 2'd2
  } exc_e;

  typedef enum logic [1:0] {
    CFG_IBASE = 2'd0,
    CFG_ILIM  = 2'd1,
    CFG_DBASE = 2'd2,
    CFG_DLIM  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/relo_regs.sv
module relo_regs #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          kind_i,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] limit_o
);
  localparam int NPAIR = 2;

  logic [AW-1:0] base_q [NPAIR];
  logic [AW-1:0] lim_q  [NPAIR];

  // sel[1] picks the pair, sel[0] picks base (0) or limit (1)
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[p] <= '0;
        lim_q[p]  <= '0;
      end else if (we_i && (sel_i[1] == p[0])) begin
        if (sel_i[0]) lim_q[p]  <= wdata_i;
        else          base_q[p] <= wdata_i;
      end
    end
  end

  assign base_o  = base_q[kind_i];
  assign limit_o = lim_q[kind_i];
endmodule

// File: rtl/relo_range_chk.sv
module relo_range_chk #(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  logic          vec_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] stride_i,
  input  logic [LW-1:0] len_i,
  input  logic [AW-1:0] limit_i,
  output logic          oob_o
);
  localparam int PW = AW + LW + 1;

  logic [LW-1:0] len_m1;
  logic [PW-1:0] span;
  logic [PW-1:0] last;
  logic          carry, first_oob, last_oob;

  always_comb begin
    len_m1    = len_i - LW'(1);
    span      = PW'(stride_i) * PW'(len_m1);
    last      = PW'(addr_i) + span;
    carry     = |last[PW-1:AW];
    first_oob = addr_i >= limit_i;
    last_oob  = last[AW-1:0] >= limit_i;
    if (!vec_i)            oob_o = first_oob;
    else if (len_i == '0)  oob_o = 1'b0;
    else                   oob_o = first_oob | last_oob | carry;
  end
endmodule

// File: rtl/relo_fault_trk.sv
module relo_fault_trk
  import relo_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          oob_i,
  input  logic          kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic          clr_i,
  output logic          fault_o,
  output exc_e          code_o,
  output logic          held_o,
  output logic [AW-1:0] err_addr_o,
  output exc_e          err_code_o
);
  logic hit;
  exc_e code_d;

  assign hit    = acc_i & oob_i;
  assign code_d = kind_i ? EXC_OPER : EXC_PROG;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o <= 1'b0;
      code_o  <= EXC_NONE;
    end else begin
      fault_o <= hit;
      code_o  <= hit ? code_d : EXC_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_o     <= 1'b0;
      err_addr_o <= '0;
      err_code_o <= EXC_NONE;
    end else if (hit) begin
      held_o     <= 1'b1;
      err_addr_o <= addr_i;
      err_code_o <= code_d;
    end else if (clr_i) begin
      held_o     <= 1'b0;
      err_addr_o <= '0;
      err_code_o <= EXC_NONE;
    end
  end
endmodule

// File: rtl/base_limit_guard.sv
module base_limit_guard
  import relo_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_kind_i,
  input  logic          req_vec_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [AW-1:0] req_stride_i,
  input  logic [LW-1:0] req_len_i,
  output logic          mem_valid_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          fault_o,
  output logic [1:0]    fault_code_o,
  output logic          err_valid_o,
  output logic [AW-1:0] err_addr_o,
  output logic [1:0]    err_code_o,
  input  logic          err_clr_i
);
  logic [AW-1:0] base, limit;
  logic          oob, acc, held;
  exc_e          code_q, err_code_q;

  relo_regs #(.AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .kind_i  (req_kind_i),
    .base_o  (base),
    .limit_o (limit)
  );

  relo_range_chk #(.AW(AW), .LW(LW)) u_chk (
    .vec_i    (req_vec_i),
    .addr_i   (req_addr_i),
    .stride_i (req_stride_i),
    .len_i    (req_len_i),
    .limit_i  (limit),
    .oob_o    (oob)
  );

  relo_fault_trk #(.AW(AW)) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .oob_i      (oob),
    .kind_i     (req_kind_i),
    .addr_i     (req_addr_i),
    .clr_i      (err_clr_i),
    .fault_o    (fault_o),
    .code_o     (code_q),
    .held_o     (held),
    .err_addr_o (err_addr_o),
    .err_code_o (err_code_q)
  );

  assign req_ready_o  = ~held;
  assign acc          = req_valid_i & req_ready_o;
  // issue without waiting for the check; a fault cancels it next cycle
  assign mem_valid_o  = acc;
  assign mem_addr_o   = req_addr_i + base;
  assign fault_code_o = code_q;
  assign err_valid_o  = held;
  assign err_code_o   = err_code_q;
endmodule

// File: rtl/base_limit_guard_chk.sv
module base_limit_guard_chk #(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          req_kind_i,
  input logic          req_vec_i,
  input logic [LW-1:0] req_len_i,
  input logic          mem_valid_o,
  input logic          fault_o,
  input logic [1:0]    fault_code_o,
  input logic          err_valid_o,
  input logic [AW-1:0] err_addr_o,
  input logic          err_clr_i
);
  p_code_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_code_o != 2'd3);

  p_fault_follows_issue_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(mem_valid_o));

  p_prog_is_fetch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_code_o == 2'd1) |-> $past(req_kind_i == 1'b0));

  p_oper_is_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_code_o == 2'd2) |-> $past(req_kind_i == 1'b1));

  p_zero_len_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_vec_i && req_len_i == '0) |=> !fault_o);

  p_err_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_o && !err_clr_i) |=> (err_valid_o && $stable(err_addr_o)));

  p_no_issue_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_o && $past(err_valid_o)) |-> !mem_valid_o);
endmodule

bind base_limit_guard base_limit_guard_chk #(.AW(AW), .LW(LW)) u_guard_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_kind_i   (req_kind_i),
  .req_vec_i    (req_vec_i),
  .req_len_i    (req_len_i),
  .mem_valid_o  (mem_valid_o),
  .fault_o      (fault_o),
  .fault_code_o (fault_code_o),
  .err_valid_o  (err_valid_o),
  .err_addr_o   (err_addr_o),
  .err_clr_i    (err_clr_i)
);

// File: tb/base_limit_guard_test.sv
module base_limit_guard_test;
  localparam int AW = 32;
  localparam int LW = 8;
  localparam int NV = 11;

  typedef struct packed {
    logic          kind;
    logic          vec;
    logic [AW-1:0] addr;
    logic [AW-1:0] stride;
    logic [LW-1:0] len;
    logic [AW-1:0] phys;
    logic [1:0]    code;
  } vec_t;

  // ibase 0x1000 ilim 0x100, dbase 0x8000 dlim 0x400
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 32'h0,     32'h0,         8'd0,  32'h1000, 2'd0}, // R1 R2
    '{1'b0, 1'b0, 32'hFF,    32'h0,         8'd0,  32'h10FF, 2'd0}, // R2
    '{1'b0, 1'b0, 32'h100,   32'h0,         8'd0,  32'h1100, 2'd1}, // R2
    '{1'b1, 1'b0, 32'h3FF,   32'h0,         8'd0,  32'h83FF, 2'd0}, // R3
    '{1'b1, 1'b0, 32'h400,   32'h0,         8'd0,  32'h8400, 2'd2}, // R3
    '{1'b1, 1'b1, 32'h10,    32'h10,        8'd63, 32'h8010, 2'd0}, // R5
    '{1'b1, 1'b1, 32'h10,    32'h10,        8'd64, 32'h8010, 2'd2}, // R5
    '{1'b1, 1'b1, 32'h500,   32'h10,        8'd0,  32'h8500, 2'd0}, // R7
    '{1'b1, 1'b1, 32'h10,    32'h80000000,  8'd3,  32'h8010, 2'd2}, // R6
    '{1'b0, 1'b1, 32'h0,     32'h8,         8'd33, 32'h1000, 2'd1}, // R5
    '{1'b1, 1'b1, 32'h3F0,   32'h1,         8'd16, 32'h83F0, 2'd0}  // R5
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [1:0]    cfg_sel_i = '0;
  logic [AW-1:0] cfg_wdata_i = '0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic          req_kind_i = 1'b0;
  logic          req_vec_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [AW-1:0] req_stride_i = '0;
  logic [LW-1:0] req_len_i = '0;
  logic          mem_valid_o;
  logic [AW-1:0] mem_addr_o;
  logic          fault_o;
  logic [1:0]    fault_code_o;
  logic          err_valid_o;
  logic [AW-1:0] err_addr_o;
  logic [1:0]    err_code_o;
  logic          err_clr_i = 1'b0;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  base_limit_guard #(.AW(AW), .LW(LW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_kind_i(req_kind_i), .req_vec_i(req_vec_i), .req_addr_i(req_addr_i),
    .req_stride_i(req_stride_i), .req_len_i(req_len_i),
    .mem_valid_o(mem_valid_o), .mem_addr_o(mem_addr_o),
    .fault_o(fault_o), .fault_code_o(fault_code_o),
    .err_valid_o(err_valid_o), .err_addr_o(err_addr_o), .err_code_o(err_code_o),
    .err_clr_i(err_clr_i)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [AW-1:0] val);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = val;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  // drive at negedge; physical address is visible in the same cycle
  task automatic issue(input logic kind, input logic vec, input logic [AW-1:0] addr,
                       input logic [AW-1:0] stride, input logic [LW-1:0] len);
    @(negedge clk);
    req_valid_i = 1'b1; req_kind_i = kind; req_vec_i = vec;
    req_addr_i = addr; req_stride_i = stride; req_len_i = len;
    #1;
  endtask

  task automatic retire;
    @(negedge clk);
    req_valid_i = 1'b0;
    #1;
  endtask

  task automatic clear;
    err_clr_i = 1'b1;
    @(negedge clk);
    err_clr_i = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R4 ready after reset", 64'(req_ready_o), 64'd1);
    chk("R4 no fault after reset", 64'(fault_o), 64'd0);
    chk("R8 code none after reset", 64'(fault_code_o), 64'd0);
    chk("R4 nothing held after reset", 64'(err_valid_o), 64'd0);

    // zero registers: base 0, every access faults
    issue(1'b1, 1'b0, 32'h20, '0, '0);
    chk("R4 zero base", 64'(mem_addr_o), 64'h20);
    chk("R1 mem valid", 64'(mem_valid_o), 64'd1);
    retire();
    chk("R4 zero limit faults", 64'(fault_code_o), 64'd2);
    chk("R8 fault pulse", 64'(fault_o), 64'd1);
    @(negedge clk); #1;
    chk("R8 fault one cycle", 64'(fault_o), 64'd0);
    chk("R9 ready low while held", 64'(req_ready_o), 64'd0);
    chk("R9 held addr", 64'(err_addr_o), 64'h20);
    chk("R9 held code", 64'(err_code_o), 64'd2);
    req_valid_i = 1'b1;
    #1;
    chk("R9 no issue while held", 64'(mem_valid_o), 64'd0);
    req_valid_i = 1'b0;
    clear();
    chk("R9 cleared", 64'(err_valid_o), 64'd0);
    chk("R9 ready after clear", 64'(req_ready_o), 64'd1);

    cfg(2'd0, 32'h1000); // R11 encoding
    cfg(2'd1, 32'h100);
    cfg(2'd2, 32'h8000);
    cfg(2'd3, 32'h400);

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].kind, TBL[i].vec, TBL[i].addr, TBL[i].stride, TBL[i].len);
      chk($sformatf("R1 phys entry %0d", i), 64'(mem_addr_o), 64'(TBL[i].phys));
      retire();
      chk($sformatf("R2 R3 R5 R6 R7 code entry %0d", i), 64'(fault_code_o), 64'(TBL[i].code));
      chk($sformatf("R8 fault entry %0d", i), 64'(fault_o), 64'(TBL[i].code != 2'd0));
      if (TBL[i].code != 2'd0) begin
        chk($sformatf("R9 err addr entry %0d", i), 64'(err_addr_o), 64'(TBL[i].addr));
        clear();
      end
    end

    // R10: write in the same cycle as a fetch
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = 2'd0; cfg_wdata_i = 32'h2000;
    req_valid_i = 1'b1; req_kind_i = 1'b0; req_vec_i = 1'b0; req_addr_i = 32'h4;
    #1;
    chk("R10 old base same cycle", 64'(mem_addr_o), 64'h1004);
    @(negedge clk);
    cfg_we_i = 1'b0;
    #1;
    chk("R10 new base next cycle", 64'(mem_addr_o), 64'h2004);
    retire();

    // R10: limit write same cycle still uses old limit
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = 2'd3; cfg_wdata_i = 32'h800;
    req_valid_i = 1'b1; req_kind_i = 1'b1; req_addr_i = 32'h500;
    @(negedge clk);
    cfg_we_i = 1'b0; req_valid_i = 1'b0;
    #1;
    chk("R10 old limit used", 64'(fault_code_o), 64'd2);
    clear();
    issue(1'b1, 1'b0, 32'h500, '0, '0);
    retire();
    chk("R10 R11 new data limit", 64'(fault_code_o), 64'd0);
    issue(1'b0, 1'b0, 32'h500, '0, '0);
    retire();
    chk("R2 R3 pairs separate", 64'(fault_code_o), 64'd1);
    clear();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule